// File: doc/BRIEF.md
# Full-Speed End-of-Packet Detector

This block watches the two line receivers of a full-speed serial bus port. One receiver flags a single-ended zero (both data lines low). The other flags the idle J level. The block decides when a packet has ended. It runs on the 4x oversampling clock (48 MHz, about 20.8 ns per sample). Both raw flags pass through a synchronizer before use. A small state machine then measures how long each single-ended-zero run lasts, in samples. A run that is too short is dropped as a glitch. A run that is long enough arms the machine. The machine then waits for the J level that must close the end-of-packet.

The two receivers are not aligned with each other. Because of that, the sample between the end of the zero and the start of J may be neither level. The machine allows a configurable number of such in-between samples. If more of them arrive, it drops the armed state and gives no result. When J closes a qualified zero, the block raises a registered strobe for exactly one clock. The packet-level logic in the slower bit-clock domain uses that strobe.

With the default limit of three samples, a zero of 62.5 ns or more is always accepted. That satisfies the 82 ns acceptance rule. A zero of one or two samples is always rejected. That covers the rule that pulses under 40 ns must be rejected.

Top module: `fs_eop_detect`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `eop_o` is 0. Any partly measured zero run is discarded by reset, so a J that follows the release produces no strobe.
- R2: Each raw input passes through `SYNC_STAGES` flip-flops. When a closing J is first presented at the pins before clock edge k, `eop_o` is high in the cycle that follows edge k+`SYNC_STAGES`.
- R3: A run of fewer than `MIN_SE0` consecutive zero samples (default 3), followed by J, produces no strobe.
- R4: A run of `MIN_SE0` or more consecutive zero samples, followed directly by J, produces exactly one strobe.
- R5: After a qualified run, up to `MAX_GAP` samples (default 1) that are neither zero nor J may come before the J, and the strobe is still produced.
- R6: After a qualified run, if more than `MAX_GAP` samples that are neither zero nor J arrive in a row, the detector returns to idle. A J that follows produces no strobe.
- R7: A zero sample that arrives during the in-between window returns the detector to the qualified state. A later J then produces the strobe.
- R8: A sample in which both the zero flag and the J flag are high counts as a zero sample.
- R9: `eop_o` is never high for two cycles in a row, even while J is held.
- R10: J samples, or in-between samples, with no qualified zero before them produce no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4x oversampling clock |
| rst | input | 1 | Synchronous reset, active high |
| line_se0_i | input | 1 | Raw single-ended-zero flag from the line receiver, asynchronous |
| line_j_i | input | 1 | Raw J-level flag from the differential receiver, asynchronous |
| eop_o | output | 1 | One-cycle end-of-packet strobe, registered |

## Verification
The bench builds the block with its defaults: `SYNC_STAGES` = 2, `MIN_SE0` = 3 and `MAX_GAP` = 1. With these values, zero widths of 1 to 6 samples land on both sides of the acceptance threshold. A gap of one in-between sample is accepted, and a gap of two or three is rejected. The expected strobe position is derived from the synchronizer depth, so each accepted case also checks the latency to the exact cycle. Directed cases cover a zero that returns inside the gap window, samples with both flags high, J with no zero before it, and a reset that cuts a run short.

// File: rtl/eop_det_pkg.sv
package eop_det_pkg;

  // Classification of one synchronized line sample
  typedef enum logic [1:0] {
    LC_OTHER = 2'd0,
    LC_J     = 2'd1,
    LC_SE0   = 2'd2
  } line_cls_e;

  // Width-filter states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_ARMED = 2'd2,
    ST_DEAD  = 2'd3
  } eop_state_e;

endpackage

// File: rtl/eop_line_sync.sv
module eop_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // One independent flop chain per asynchronous input bit
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
      end else begin
        chain <= {chain[STAGES-2:0], d_i[b]};
      end
    end

    assign q_o[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/eop_line_class.sv
module eop_line_class
  import eop_det_pkg::*;
(
  input  logic      se0_i,
  input  logic      j_i,
  output line_cls_e cls_o
);

  // A zero indication dominates: J is only meaningful when the zero flag is clear
  always_comb begin
    if (se0_i) begin
      cls_o = LC_SE0;
    end else if (j_i) begin
      cls_o = LC_J;
    end else begin
      cls_o = LC_OTHER;
    end
  end

endmodule

// File: rtl/eop_width_fsm.sv
module eop_width_fsm
  import eop_det_pkg::*;
#(
  parameter int MIN_SE0 = 3,
  parameter int MAX_GAP = 1
) (
  input  logic      clk,
  input  logic      rst,
  input  line_cls_e cls_i,
  output logic      eop_o
);

  localparam int RUN_W = $clog2(MIN_SE0 + 1);
  localparam int GAP_W = $clog2(MAX_GAP + 2);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_SE0 - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(MAX_GAP);

  eop_state_e       state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             eop_q, eop_d;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    gap_d   = gap_q;
    eop_d   = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (cls_i == LC_SE0) begin
          if (MIN_SE0 <= 1) begin
            state_d = ST_ARMED;
          end else begin
            state_d = ST_RUN;
          end
          run_d = RUN_W'(1);
        end
      end

      ST_RUN: begin
        if (cls_i == LC_SE0) begin
          if (run_q == RUN_LAST) begin
            state_d = ST_ARMED;
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end else begin
          // Run ended too early: glitch, drop it
          state_d = ST_IDLE;
          run_d   = '0;
        end
      end

      ST_ARMED: begin
        if (cls_i == LC_J) begin
          eop_d   = 1'b1;
          state_d = ST_IDLE;
          run_d   = '0;
        end else if (cls_i == LC_OTHER) begin
          if (MAX_GAP == 0) begin
            state_d = ST_IDLE;
            run_d   = '0;
          end else begin
            state_d = ST_DEAD;
            gap_d   = GAP_W'(1);
          end
        end
      end

      ST_DEAD: begin
        if (cls_i == LC_J) begin
          eop_d   = 1'b1;
          state_d = ST_IDLE;
          run_d   = '0;
          gap_d   = '0;
        end else if (cls_i == LC_SE0) begin
          state_d = ST_ARMED;
          gap_d   = '0;
        end else if (gap_q == GAP_LAST) begin
          state_d = ST_IDLE;
          run_d   = '0;
          gap_d   = '0;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      run_q   <= '0;
      gap_q   <= '0;
      eop_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      gap_q   <= gap_d;
      eop_q   <= eop_d;
    end
  end

  assign eop_o = eop_q;

endmodule

// File: rtl/fs_eop_detect.sv
module fs_eop_detect
  import eop_det_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_SE0     = 3,
  parameter int MAX_GAP     = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic line_se0_i,
  input  logic line_j_i,
  output logic eop_o
);

  logic [1:0] sync_q;
  logic       se0_s;
  logic       j_s;
  line_cls_e  cls;

  eop_line_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({line_se0_i, line_j_i}),
    .q_o (sync_q)
  );

  assign se0_s = sync_q[1];
  assign j_s   = sync_q[0];

  eop_line_class u_class (
    .se0_i (se0_s),
    .j_i   (j_s),
    .cls_o (cls)
  );

  eop_width_fsm #(
    .MIN_SE0 (MIN_SE0),
    .MAX_GAP (MAX_GAP)
  ) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .cls_i (cls),
    .eop_o (eop_o)
  );

endmodule

// File: rtl/eop_detect_chk.sv
module eop_detect_chk #(
  parameter int MIN_SE0 = 3,
  parameter int MAX_GAP = 1
) (
  input logic clk,
  input logic rst,
  input logic se0_s,
  input logic j_s,
  input logic eop_o
);

  // Independent model of the width rules: consecutive zero count,
  // consecutive in-between count, and whether a long enough zero was seen
  int   run_c;
  int   gap_c;
  logic qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_c <= 0;
      gap_c <= 0;
      qual  <= 1'b0;
    end else begin
      if (se0_s) begin
        gap_c <= 0;
        if (run_c < MIN_SE0) run_c <= run_c + 1;
        if (run_c + 1 >= MIN_SE0) qual <= 1'b1;
        else if (eop_o) qual <= 1'b0;
      end else begin
        run_c <= 0;
        if (!j_s) begin
          if (gap_c <= MAX_GAP) gap_c <= gap_c + 1;
          if (gap_c + 1 > MAX_GAP || eop_o) qual <= 1'b0;
        end else begin
          gap_c <= 0;
          if (eop_o) qual <= 1'b0;
        end
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !eop_o)
    else $error("R1: strobe after reset");

  p_needs_width_r3: assert property (@(posedge clk) disable iff (rst) eop_o |-> qual)
    else $error("R3: strobe without a qualified zero run");

  p_needs_j_r4: assert property (@(posedge clk) disable iff (rst)
    eop_o |-> $past(j_s && !se0_s))
    else $error("R4: strobe not caused by a J sample");

  p_gap_limit_r6: assert property (@(posedge clk) disable iff (rst)
    eop_o |-> (gap_c <= MAX_GAP))
    else $error("R6: strobe after too long a gap");

  p_se0_dominates_r8: assert property (@(posedge clk) disable iff (rst)
    (se0_s && j_s) |=> !eop_o)
    else $error("R8: both flags treated as J");

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst) eop_o |=> !eop_o)
    else $error("R9: strobe longer than one cycle");

endmodule

bind fs_eop_detect eop_detect_chk #(
  .MIN_SE0 (MIN_SE0),
  .MAX_GAP (MAX_GAP)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .se0_s (se0_s),
  .j_s   (j_s),
  .eop_o (eop_o)
);

// File: tb/fs_eop_detect_test.sv
module fs_eop_detect_test;

  localparam int SYNC_STAGES = 2;
  localparam int MIN_SE0     = 3;
  localparam int MAX_GAP     = 1;
  localparam int LAT         = SYNC_STAGES + 1;

  // Sample codes used in patterns: 0 = J, 1 = zero, 2 = neither, 3 = both flags
  localparam logic [1:0] C_J = 2'd0, C_Z = 2'd1, C_N = 2'd2, C_B = 2'd3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic se0 = 1'b0;
  logic j   = 1'b1;
  logic eop;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  fs_eop_detect #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_SE0     (MIN_SE0),
    .MAX_GAP     (MAX_GAP)
  ) uut (
    .clk        (clk),
    .rst        (rst),
    .line_se0_i (se0),
    .line_j_i   (j),
    .eop_o      (eop)
  );

  // {zero width, in-between samples, strobe expected}
  localparam int NV = 15;
  localparam logic [8:0] VEC [NV] = '{
    {4'd1, 4'd0, 1'b0}, {4'd2, 4'd0, 1'b0}, {4'd3, 4'd0, 1'b1},
    {4'd4, 4'd0, 1'b1}, {4'd5, 4'd0, 1'b1}, {4'd6, 4'd0, 1'b1},
    {4'd1, 4'd1, 1'b0}, {4'd2, 4'd1, 1'b0}, {4'd3, 4'd1, 1'b1},
    {4'd4, 4'd1, 1'b1}, {4'd5, 4'd1, 1'b1}, {4'd6, 4'd1, 1'b1},
    {4'd3, 4'd2, 1'b0}, {4'd6, 4'd2, 1'b0}, {4'd4, 4'd3, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] c);
    case (c)
      C_J:     begin se0 = 1'b0; j = 1'b1; end
      C_Z:     begin se0 = 1'b1; j = 1'b0; end
      C_N:     begin se0 = 1'b0; j = 1'b0; end
      default: begin se0 = 1'b1; j = 1'b1; end
    endcase
  endtask

  // Drive len samples of pat, then hold J; count strobe cycles and first position
  task automatic run_seq(input logic [31:0] pat, input int len, input int exp_cnt,
                         input int exp_at, input string req);
    int cnt   = 0;
    int first = -1;
    for (int t = 0; t < len + LAT + 6; t++) begin
      @(negedge clk);
      if (eop) begin
        cnt++;
        if (first < 0) first = t;
      end
      if (t < len) put(pat[2*t +: 2]);
      else         put(C_J);
    end
    check(cnt == exp_cnt, req, "strobe cycles", cnt, exp_cnt);
    if (exp_cnt > 0) check(first == exp_at, {req, "/R2"}, "strobe position", first, exp_at);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] pat;
    int          cnt;

    // R1: quiet during and right after reset
    put(C_J);
    repeat (4) @(negedge clk);
    check(eop == 1'b0, "R1", "strobe in reset", int'(eop), 0);
    rst = 1'b0;
    @(negedge clk);
    check(eop == 1'b0, "R1", "strobe after release", int'(eop), 0);

    // R10: idle J produces nothing
    cnt = 0;
    repeat (10) begin @(negedge clk); if (eop) cnt++; end
    check(cnt == 0, "R10", "strobes on idle J", cnt, 0);

    // Table walk: zero widths and gaps (R3, R4, R5, R6, R9)
    for (int v = 0; v < NV; v++) begin
      int w = int'(VEC[v][8:5]);
      int g = int'(VEC[v][4:1]);
      int e = int'(VEC[v][0]);
      string req;
      pat = '0;
      for (int s = 0; s < w; s++) pat[2*s +: 2] = C_Z;
      for (int s = 0; s < g; s++) pat[2*(w+s) +: 2] = C_N;
      if (g > MAX_GAP)     req = "R6";
      else if (e == 0)     req = "R3";
      else if (g > 0)      req = "R5";
      else                 req = "R4/R9";
      run_seq(pat, w + g, e, w + g + LAT, req);
    end

    // R7: zero returns inside the gap window
    pat = '0;
    pat[1:0] = C_Z; pat[3:2] = C_Z; pat[5:4] = C_Z;
    pat[7:6] = C_N; pat[9:8] = C_Z; pat[11:10] = C_Z;
    run_seq(pat, 6, 1, 6 + LAT, "R7");

    // R8: both flags high counted as zero
    pat = '0;
    pat[1:0] = C_B; pat[3:2] = C_B; pat[5:4] = C_B;
    run_seq(pat, 3, 1, 3 + LAT, "R8");

    // R8: two zero samples then a both-flags sample still reach the width
    pat = '0;
    pat[1:0] = C_Z; pat[3:2] = C_Z; pat[5:4] = C_B;
    run_seq(pat, 3, 1, 3 + LAT, "R8");

    // R10: in-between samples with no zero, then J
    pat = '0;
    pat[1:0] = C_N; pat[3:2] = C_N; pat[5:4] = C_N;
    run_seq(pat, 3, 0, 0, "R10");

    // R9: long zero, then J held well past the strobe
    pat = '0;
    for (int s = 0; s < 14; s++) pat[2*s +: 2] = C_Z;
    run_seq(pat, 14, 1, 14 + LAT, "R9");

    // R1: reset in the middle of a qualified zero discards it
    @(negedge clk);
    put(C_Z);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    put(C_J);
    cnt = 0;
    repeat (10) begin @(negedge clk); if (eop) cnt++; end
    check(cnt == 0, "R1", "strobes after reset cut a run", cnt, 0);

    summary();
    $finish;
  end

endmodule